// File: doc/BRIEF.md
# Periodic Microframe Mask Qualifier

This block decides, once per presented descriptor, whether a periodic-schedule endpoint descriptor should run in the current microframe. The low bits of the frame index pick one position in each of two per-microframe bit masks. The first mask schedules normal transfers and start-splits. The second schedules complete-splits. The endpoint speed code and the split-state bit decide which mask applies and which transaction kind is reported.

A scheduler places one descriptor's fields on the inputs. One clock later it reads a candidate strobe, a transaction-kind code and a pass-through PID code. Mask combinations that have no defined meaning raise an error flag. They never produce a candidate. Fetching descriptors, running transactions and interpreting PIDs are left to the surrounding logic.

Top module: `mfq_qualifier`

## Requirements
- R1: While `rst` is high and on the first sampling after it, `cand_o`, `err_o`, `kind_o` and `pid_o` are all zero.
- R2: Every output reflects the inputs presented before the previous rising clock edge. There is exactly one cycle of latency, and an input change does not show before that edge.
- R3: With speed code 2'b10 (high speed), the descriptor active, the descriptor on the periodic list and no error, `cand_o` is 1 exactly when the start-mask bit selected by `uf_index` is 1. The kind is then 2'b01 and `pid_o` equals `hs_pid`.
- R4: With speed code 2'b00 (full) or 2'b01 (low), `split_st`=0 (start-split to do), the descriptor active and on the periodic list, and no error, `cand_o` is 1 exactly when the selected start-mask bit is 1. The kind is then 2'b10 and `pid_o` is 0.
- R5: With speed code 2'b00 or 2'b01, `split_st`=1 (complete-split to do), the descriptor active and on the periodic list, and no error, `cand_o` is 1 exactly when the complete-mask bit selected by `uf_index` is 1. The kind is then 2'b11.
- R6: For high speed, and for full or low speed with `split_st`=0, a non-zero complete-mask has no effect on any output.
- R7: A descriptor on the periodic list with a zero start-mask raises `err_o`.
- R8: A descriptor on the periodic list with speed 2'b00 or 2'b01 and a zero complete-mask raises `err_o`.
- R9: A descriptor from the asynchronous list (`periodic`=0) never gives a candidate. It raises `err_o` when its start-mask is non-zero.
- R10: With `active`=0, `cand_o` is 0 and the kind is 2'b00.
- R11: Speed code 2'b11 is reserved and forces `cand_o` to 0.
- R12: Whenever `err_o` is 1, `cand_o` is 0, the kind is 2'b00 and `pid_o` is 0. Whenever `cand_o` is 0, the kind is 2'b00.
- R13: Every set bit of a mask makes the descriptor a candidate in its own microframe, so a mask with several bits set gives candidacy in several microframes of one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uf_index | input | IDX_W (3) | Low bits of the frame index (microframe number) |
| start_mask | input | 2**IDX_W (8) | Per-microframe start/normal schedule mask |
| cmpl_mask | input | 2**IDX_W (8) | Per-microframe complete-split schedule mask |
| speed | input | 2 | 00 full, 01 low, 10 high, 11 reserved |
| split_st | input | 1 | 0 start-split pending, 1 complete-split pending |
| active | input | 1 | Descriptor holds an active transfer |
| periodic | input | 1 | 1 when the descriptor comes from the periodic list |
| hs_pid | input | 2 | PID code for high-speed transactions |
| cand_o | output | 1 | Candidate strobe (registered) |
| kind_o | output | 2 | 00 none, 01 high speed, 10 start-split, 11 complete-split |
| pid_o | output | 2 | `hs_pid` for high-speed candidates, else 0 |
| err_o | output | 1 | Undefined mask combination |

## Verification
The state in this block is a single output register, so any wrong selection or classification shows at the ports one cycle after the inputs that cause it. A wrong index decode shows up as candidacy in the wrong microframe for some mask pattern. Because the bench sweeps every microframe index against mixed-bit masks, it finds such a fault in the cycle after the bad vector. Mixing up speed codes or split states shows as a wrong kind code or a wrong error flag on that same next cycle.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_LOW  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_RSV  = 2'b11
  } speed_t;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_HS    = 2'b01,
    KIND_SSPLT = 2'b10,
    KIND_CSPLT = 2'b11
  } kind_t;

  typedef struct packed {
    logic       cand;
    kind_t      kind;
    logic [1:0] pid;
    logic       err;
  } verdict_t;
endpackage

// File: rtl/mfq_bit_pick.sv
module mfq_bit_pick #(
  parameter int IDX_W  = 3,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [IDX_W-1:0]  idx,
  output logic              bit_o,
  output logic              nz_o
);
  logic [MASK_W-1:0] sel;

  for (genvar i = 0; i < MASK_W; i++) begin : g_dec
    assign sel[i] = (idx == IDX_W'(i));
  end

  assign bit_o = |(mask & sel);
  assign nz_o  = |mask;
endmodule

// File: rtl/mfq_decide.sv
module mfq_decide
  import mfq_pkg::*;
(
  input  logic       s_bit,
  input  logic       s_nz,
  input  logic       c_bit,
  input  logic       c_nz,
  input  logic [1:0] speed,
  input  logic       split_st,
  input  logic       active,
  input  logic       periodic,
  input  logic [1:0] hs_pid,
  output verdict_t   v
);
  logic is_hs, is_fsls, cm_use, err, hit, cand;

  always_comb begin
    is_hs   = (speed == SPD_HIGH);
    is_fsls = (speed == SPD_FULL) || (speed == SPD_LOW);
    cm_use  = periodic && is_fsls;
    err     = (periodic && !s_nz) || (cm_use && !c_nz) || (!periodic && s_nz);
    hit     = (is_fsls && split_st) ? c_bit : s_bit;
    cand    = active && periodic && (is_hs || is_fsls) && !err && hit;

    v.cand = cand;
    v.err  = err;
    v.pid  = 2'b00;
    if (!cand)         v.kind = KIND_NONE;
    else if (is_hs)    v.kind = KIND_HS;
    else if (split_st) v.kind = KIND_CSPLT;
    else               v.kind = KIND_SSPLT;
    if (cand && is_hs) v.pid = hs_pid;
  end
endmodule

// File: rtl/mfq_out_reg.sv
module mfq_out_reg
  import mfq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t d,
  output verdict_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/mfq_qualifier.sv
module mfq_qualifier
  import mfq_pkg::*;
#(
  parameter int IDX_W  = 3,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  uf_index,
  input  logic [MASK_W-1:0] start_mask,
  input  logic [MASK_W-1:0] cmpl_mask,
  input  logic [1:0]        speed,
  input  logic              split_st,
  input  logic              active,
  input  logic              periodic,
  input  logic [1:0]        hs_pid,
  output logic              cand_o,
  output logic [1:0]        kind_o,
  output logic [1:0]        pid_o,
  output logic              err_o
);
  logic     s_bit, s_nz, c_bit, c_nz;
  verdict_t v_d, v_q;

  mfq_bit_pick #(.IDX_W(IDX_W)) u_spick (
    .mask(start_mask), .idx(uf_index), .bit_o(s_bit), .nz_o(s_nz)
  );

  mfq_bit_pick #(.IDX_W(IDX_W)) u_cpick (
    .mask(cmpl_mask), .idx(uf_index), .bit_o(c_bit), .nz_o(c_nz)
  );

  mfq_decide u_decide (
    .s_bit(s_bit), .s_nz(s_nz), .c_bit(c_bit), .c_nz(c_nz),
    .speed(speed), .split_st(split_st), .active(active),
    .periodic(periodic), .hs_pid(hs_pid), .v(v_d)
  );

  mfq_out_reg u_oreg (.clk(clk), .rst(rst), .d(v_d), .q(v_q));

  assign cand_o = v_q.cand;
  assign kind_o = v_q.kind;
  assign pid_o  = v_q.pid;
  assign err_o  = v_q.err;
endmodule

// File: rtl/mfq_qualifier_chk.sv
module mfq_qualifier_chk #(
  parameter int IDX_W  = 3,
  localparam int MASK_W = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  uf_index,
  input logic [MASK_W-1:0] start_mask,
  input logic [MASK_W-1:0] cmpl_mask,
  input logic [1:0]        speed,
  input logic              split_st,
  input logic              active,
  input logic              periodic,
  input logic [1:0]        hs_pid,
  input logic              cand_o,
  input logic [1:0]        kind_o,
  input logic [1:0]        pid_o,
  input logic              err_o
);
  AST_RSV_SPEED: assert property (@(posedge clk) disable iff (rst) (speed == 2'b11) |=> !cand_o); // R11
  AST_INACTIVE: assert property (@(posedge clk) disable iff (rst) !active |=> (!cand_o && kind_o == 2'b00)); // R10
  AST_ASYNC_NO_CAND: assert property (@(posedge clk) disable iff (rst) !periodic |=> !cand_o); // R9
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst) err_o |-> (!cand_o && kind_o == 2'b00 && pid_o == 2'b00)); // R12
  AST_KIND_NONE: assert property (@(posedge clk) disable iff (rst) !cand_o |-> kind_o == 2'b00); // R12
  AST_PER_ZERO_SMASK: assert property (@(posedge clk) disable iff (rst) (periodic && start_mask == '0) |=> err_o); // R7
  AST_CMASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (periodic && speed[1] == 1'b0 && cmpl_mask == '0) |=> err_o); // R8
  AST_SS_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    (cand_o && kind_o != 2'b11) |-> $past(start_mask[uf_index])); // R4
  AST_CS_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    (cand_o && kind_o == 2'b11) |-> $past(cmpl_mask[uf_index])); // R5
  AST_HS_PID: assert property (@(posedge clk) disable iff (rst)
    (cand_o && kind_o == 2'b01) |-> pid_o == $past(hs_pid)); // R3
endmodule

bind mfq_qualifier mfq_qualifier_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/mfq_qualifier_bench.sv
module mfq_qualifier_bench;
  localparam int IDX_W = 3;
  localparam int MW    = 1 << IDX_W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IDX_W-1:0] uf_index = '0;
  logic [MW-1:0] start_mask = '0, cmpl_mask = '0;
  logic [1:0]    speed = 2'b00, hs_pid = 2'b00;
  logic          split_st = 1'b0, active = 1'b0, periodic = 1'b0;
  logic          cand_o, err_o;
  logic [1:0]    kind_o, pid_o;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mfq_qualifier #(.IDX_W(IDX_W)) u_mfq_qualifier (
    .clk(clk), .rst(rst), .uf_index(uf_index), .start_mask(start_mask),
    .cmpl_mask(cmpl_mask), .speed(speed), .split_st(split_st), .active(active),
    .periodic(periodic), .hs_pid(hs_pid), .cand_o(cand_o), .kind_o(kind_o),
    .pid_o(pid_o), .err_o(err_o)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {cand,kind,pid,err}=%b expected %b (idx=%0d s=%h c=%h spd=%b sp=%b a=%b p=%b)",
               req, act, exp, uf_index, start_mask, cmpl_mask, speed, split_st, active, periodic);
    end
  endtask

  function automatic logic [5:0] model(logic [2:0] ix, logic [7:0] sm, logic [7:0] cm,
                                       logic [1:0] sp, logic sl, logic ac, logic pe, logic [1:0] pd);
    logic e, h, c, fl, hs;
    logic [1:0] k, p;
    hs = (sp == 2'd2);
    fl = (sp < 2'd2);
    e  = (pe && sm == 0) || (pe && fl && cm == 0) || (!pe && sm != 0);
    h  = (fl && sl) ? ((cm >> ix) & 8'd1) != 0 : ((sm >> ix) & 8'd1) != 0;
    c  = ac && pe && (hs || fl) && !e && h;
    k  = !c ? 2'd0 : hs ? 2'd1 : sl ? 2'd3 : 2'd2;
    p  = (c && hs) ? pd : 2'd0;
    return {c, k, p, e};
  endfunction

  function automatic string tag(logic [7:0] sm, logic [7:0] cm, logic [1:0] sp,
                                logic sl, logic ac, logic pe);
    if (sp == 2'd3)                return "R11";
    if (!pe)                       return "R9";
    if (sm == 0)                   return "R7 R12";
    if (sp < 2'd2 && cm == 0)      return "R8 R12";
    if (!ac)                       return "R10";
    if (sp == 2'd2)                return "R3 R6 R13";
    if (!sl)                       return "R4 R6 R13";
    return "R5 R13";
  endfunction

  function automatic logic [7:0] spat(int i);
    case (i) 0: return 8'h00; 1: return 8'h01; 2: return 8'hA5; default: return 8'hFF; endcase
  endfunction
  function automatic logic [7:0] cpat(int i);
    case (i) 0: return 8'h00; 1: return 8'h80; 2: return 8'h5A; default: return 8'hFF; endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {cand_o, kind_o, pid_o, err_o}, 6'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {cand_o, kind_o, pid_o, err_o}, 6'b0);

    // R2: one-cycle latency
    uf_index = 3'd2; start_mask = 8'h04; cmpl_mask = 8'h00; speed = 2'd2;
    active = 1'b1; periodic = 1'b1; hs_pid = 2'd3; split_st = 1'b0;
    @(negedge clk);
    check("R2 R3", {cand_o, kind_o, pid_o, err_o}, 6'b101110);
    prev = {cand_o, kind_o, pid_o, err_o};
    active = 1'b0;
    #1 check("R2", {cand_o, kind_o, pid_o, err_o}, prev);
    @(negedge clk);
    check("R2 R10", {cand_o, kind_o, pid_o, err_o}, 6'b0);

    // Sweep
    for (int sp = 0; sp < 4; sp++)
      for (int pe = 0; pe < 2; pe++)
        for (int ac = 0; ac < 2; ac++)
          for (int sl = 0; sl < 2; sl++)
            for (int si = 0; si < 4; si++)
              for (int ci = 0; ci < 4; ci++)
                for (int ix = 0; ix < MW; ix++) begin
                  uf_index = 3'(ix); start_mask = spat(si); cmpl_mask = cpat(ci);
                  speed = 2'(sp); split_st = sl[0]; active = ac[0]; periodic = pe[0];
                  hs_pid = 2'((ix + si) % 4);
                  @(negedge clk);
                  check(tag(start_mask, cmpl_mask, speed, split_st, active, periodic),
                        {cand_o, kind_o, pid_o, err_o},
                        model(uf_index, start_mask, cmpl_mask, speed, split_st, active, periodic, hs_pid));
                end

    // R6: complete-mask has no effect for high speed
    uf_index = 3'd5; start_mask = 8'h20; speed = 2'd2; split_st = 1'b1;
    active = 1'b1; periodic = 1'b1; hs_pid = 2'd1; cmpl_mask = 8'h00;
    @(negedge clk);
    prev = {cand_o, kind_o, pid_o, err_o};
    check("R6", prev, 6'b101010);
    cmpl_mask = 8'hDF;
    @(negedge clk);
    check("R6", {cand_o, kind_o, pid_o, err_o}, prev);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule